// File: doc/BRIEF.md
# Call/Return Frame Unit

This unit sequences the three control-transfer operations of a stack machine that keeps its activation records in a 16-bit data memory. It handles a direct call, a call through a two-word closure on the stack, and a routine return. For a call it builds a three-word frame holding the static link, the dynamic link and the return address. For a return it takes the frame down again and moves the routine's result words to where the caller expects them. In every case it then writes the frame base, the stack top and the code pointer.

Whenever the frame base changes, the unit rebuilds the six display registers. It follows the chain of static links upward from the new frame base, one memory read per level. A call whose target lies in the primitive window, just above the normal code space, builds no frame. It is handed to an external primitive unit through a request/acknowledge pair. A call to an address above that window fails with an error. So does a call without stack room, and so does a return with too few words on the stack. In these cases nothing is written.

The instruction decoder supplies the operation, its count and displacement fields, and the values of the two named registers. It also supplies the current frame base, stack top, code pointer and heap top. The unit signals the end of every operation with a one-cycle `done_o`. The heap top is an input only and is never written.

Top module: `frame_unit`

## Requirements
- R1: `op_i` encodes 0 = CALL, 1 = CALLI and 2 = RETURN. `start_i` is taken only while `busy_o` is low. Every operation ends with a `done_o` pulse of exactly one cycle. `err_o` is high only together with `done_o`.
- R2: CALL with target T = d + Reg(r) below CODE_LIMIT writes exactly three data words: Reg(n) at ST, LB at ST+1 and CP+1 at ST+2.
- R3: After a successful CALL, LB equals the old ST, ST equals the old ST+3 and CP equals T.
- R4: CALLI reads its jump address J at ST-1 and leaves the static link at ST-2 untouched. It writes LB at ST-1 and CP+1 at ST, then sets LB = old ST-2, ST = old ST+1 and CP = J.
- R5: After every successful CALL, CALLI or RETURN, display register L1 equals mem[LB], and Lk equals mem[L(k-1)] for k = 2 to 6. Each display register is written through a one-hot enable.
- R6: A target in [CODE_LIMIT, CODE_LIMIT+PRIM_CNT) writes no data word, no display register, no LB and no ST. It raises `prim_req_o` with `prim_id_o` = target - CODE_LIMIT, holds both until `prim_ack_i`, and then sets CP = old CP+1.
- R7: A target at or above CODE_LIMIT+PRIM_CNT ends with `err_o` and no write of any kind.
- R8: CALL with ST+3 > HT, CALLI with ST+1 > HT, and CALLI with ST < 2 end with `err_o` and no write. ST+3 = HT exactly is accepted.
- R9: RETURN reads the return address at LB+2 and the saved link at LB+1. It copies the n words starting at ST-n, in ascending order, to the words starting at LB-d. It then sets LB to the saved link, CP to the return address and ST = old LB - d + n.
- R10: RETURN with n = 0 writes no data word but still restores LB, CP and ST.
- R11: RETURN with ST - LB < 3 + n, or with d > LB, ends with `err_o` and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation |
| op_i | input | 2 | Operation code |
| fld_n_i | input | NW | Count field n |
| fld_d_i | input | DW | Displacement field d |
| reg_r_val_i | input | DW | Value of Reg(r) |
| reg_n_val_i | input | DW | Value of Reg(n) |
| lb_i | input | DW | Current frame base |
| st_i | input | DW | Current stack top |
| cp_i | input | DW | Current code pointer |
| ht_i | input | DW | Heap top, the stack limit |
| mem_req_o | output | 1 | Data memory access |
| mem_we_o | output | 1 | Write strobe |
| mem_addr_o | output | DW | Word address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, one cycle after the request |
| lb_we_o | output | 1 | Frame base write enable |
| lb_o | output | DW | New frame base |
| st_we_o | output | 1 | Stack top write enable |
| st_o | output | DW | New stack top |
| cp_we_o | output | 1 | Code pointer write enable |
| cp_o | output | DW | New code pointer |
| disp_we_o | output | NDISP | One-hot display register write enable |
| disp_o | output | DW | Display register data |
| prim_req_o | output | 1 | Primitive dispatch request |
| prim_id_o | output | PIW | Primitive index |
| prim_ack_i | input | 1 | Primitive finished |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished |
| err_o | output | 1 | Operation rejected |

## Verification
CALL is run with a static link equal to the caller's frame base and with one that points further out. The two runs tell a frame word taken from Reg(n) apart from one taken from LB, and they give different display chains. CALLI and CALL are run against targets below, inside and above the primitive window. Each is also run at the exact stack limit and one word past it, which separates the frame path, the primitive path and the two rejection paths. RETURN is run with zero, one and two result words and with non-zero displacements. These runs show whether the copy direction, the destination base and the final stack top are right.

// File: rtl/frame_pkg.sv
package frame_pkg;

  typedef enum logic [1:0] {
    OP_CALL  = 2'd0,
    OP_CALLI = 2'd1,
    OP_RET   = 2'd2
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_DEC, S_CJ_RD, S_CJ_CHK, S_FRAME, S_RET_RA, S_RET_DL, S_RET_CAP,
    S_MV_RD, S_MV_WR, S_COMMIT, S_WALK, S_PRIM, S_PFIN, S_DONE, S_ERR
  } fsm_e;

endpackage

// File: rtl/frame_tgt_chk.sv
module frame_tgt_chk #(
  parameter int unsigned DW         = 16,
  parameter int unsigned CODE_LIMIT = 1024,
  parameter int unsigned PRIM_CNT   = 28
) (
  input  logic [DW-1:0] tgt_i,
  input  logic [DW-1:0] st_i,
  input  logic [DW-1:0] ht_i,
  input  logic [1:0]    need_i,
  output logic          is_code_o,
  output logic          is_prim_o,
  output logic          room_o
);
  localparam logic [DW:0] CODE_LIM = (DW+1)'(CODE_LIMIT);
  localparam logic [DW:0] PRIM_END = (DW+1)'(CODE_LIMIT + PRIM_CNT);

  logic [DW:0] tgt_w, top_w;

  assign tgt_w     = {1'b0, tgt_i};
  assign top_w     = {1'b0, st_i} + (DW+1)'(need_i);
  assign is_code_o = tgt_w < CODE_LIM;
  assign is_prim_o = (tgt_w >= CODE_LIM) && (tgt_w < PRIM_END);
  assign room_o    = top_w <= {1'b0, ht_i};
endmodule

// File: rtl/frame_disp_walk.sv
module frame_disp_walk #(
  parameter int unsigned DW    = 16,
  parameter int unsigned NDISP = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DW-1:0]    base_i,
  input  logic [DW-1:0]    rdata_i,
  output logic             rd_req_o,
  output logic [DW-1:0]    rd_addr_o,
  output logic [NDISP-1:0] disp_we_o,
  output logic [DW-1:0]    disp_o,
  output logic             done_o
);
  localparam int unsigned LW = (NDISP > 1) ? $clog2(NDISP) : 1;
  localparam logic [LW-1:0] LAST = LW'(NDISP - 1);

  typedef enum logic [1:0] {W_IDLE, W_RD, W_WR} wst_e;

  wst_e          ws_q;
  logic [DW-1:0] ptr_q;
  logic [LW-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_q  <= W_IDLE;
      ptr_q <= '0;
      lvl_q <= '0;
    end else begin
      unique case (ws_q)
        W_IDLE: if (start_i) begin
          ptr_q <= base_i;
          lvl_q <= '0;
          ws_q  <= W_RD;
        end
        W_RD: ws_q <= W_WR;
        W_WR: begin
          ptr_q <= rdata_i;
          if (lvl_q == LAST) ws_q <= W_IDLE;
          else begin
            lvl_q <= lvl_q + LW'(1);
            ws_q  <= W_RD;
          end
        end
        default: ws_q <= W_IDLE;
      endcase
    end
  end

  assign rd_req_o  = (ws_q == W_RD);
  assign rd_addr_o = ptr_q;
  assign disp_o    = rdata_i;
  assign done_o    = (ws_q == W_WR) && (lvl_q == LAST);

  for (genvar g = 0; g < NDISP; g++) begin : g_we
    assign disp_we_o[g] = (ws_q == W_WR) && (lvl_q == LW'(g));
  end
endmodule

// File: rtl/frame_unit.sv
module frame_unit
  import frame_pkg::*;
#(
  parameter int unsigned DW         = 16,
  parameter int unsigned NW         = 8,
  parameter int unsigned NDISP      = 6,
  parameter int unsigned CODE_LIMIT = 1024,
  parameter int unsigned PRIM_CNT   = 28,
  localparam int unsigned PIW       = (PRIM_CNT > 1) ? $clog2(PRIM_CNT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [NW-1:0]    fld_n_i,
  input  logic [DW-1:0]    fld_d_i,
  input  logic [DW-1:0]    reg_r_val_i,
  input  logic [DW-1:0]    reg_n_val_i,
  input  logic [DW-1:0]    lb_i,
  input  logic [DW-1:0]    st_i,
  input  logic [DW-1:0]    cp_i,
  input  logic [DW-1:0]    ht_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [DW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             lb_we_o,
  output logic [DW-1:0]    lb_o,
  output logic             st_we_o,
  output logic [DW-1:0]    st_o,
  output logic             cp_we_o,
  output logic [DW-1:0]    cp_o,
  output logic [NDISP-1:0] disp_we_o,
  output logic [DW-1:0]    disp_o,
  output logic             prim_req_o,
  output logic [PIW-1:0]   prim_id_o,
  input  logic             prim_ack_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  localparam logic [DW-1:0] CODE_BASE = DW'(CODE_LIMIT);

  fsm_e          state_q;
  op_e           op_q;
  logic [NW-1:0] n_q, cnt_q;
  logic [DW-1:0] d_q, rr_q, rn_q, lb_q, st_q, cp_q, ht_q;
  logic [DW-1:0] tgt_q, nlb_q, nst_q, ncp_q, ra_q;

  logic [DW-1:0] tgt_c, cp1_c;
  logic [1:0]    need_c, fidx_c;
  logic          is_code, is_prim, room;
  logic [DW:0]   ret_need_c;
  logic          ret_bad_c, frame_last_c;

  logic             w_req, w_done;
  logic [DW-1:0]    w_addr;

  assign tgt_c  = (state_q == S_CJ_CHK) ? mem_rdata_i : d_q + rr_q;
  assign need_c = (op_q == OP_CALLI) ? 2'd1 : 2'd3;
  assign cp1_c  = cp_q + DW'(1);

  frame_tgt_chk #(.DW(DW), .CODE_LIMIT(CODE_LIMIT), .PRIM_CNT(PRIM_CNT)) u_tgt (
    .tgt_i    (tgt_c),
    .st_i     (st_q),
    .ht_i     (ht_q),
    .need_i   (need_c),
    .is_code_o(is_code),
    .is_prim_o(is_prim),
    .room_o   (room)
  );

  assign ret_need_c   = {1'b0, lb_q} + (DW+1)'(n_q) + (DW+1)'(3);
  assign ret_bad_c    = (d_q > lb_q) || ({1'b0, st_q} < ret_need_c);
  assign fidx_c       = cnt_q[1:0] + {1'b0, op_q == OP_CALLI};
  assign frame_last_c = (op_q == OP_CALLI) ? (cnt_q == NW'(1)) : (cnt_q == NW'(2));

  frame_disp_walk #(.DW(DW), .NDISP(NDISP)) u_walk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (state_q == S_COMMIT),
    .base_i   (nlb_q),
    .rdata_i  (mem_rdata_i),
    .rd_req_o (w_req),
    .rd_addr_o(w_addr),
    .disp_we_o(disp_we_o),
    .disp_o   (disp_o),
    .done_o   (w_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_CALL;
      n_q     <= '0;
      cnt_q   <= '0;
      d_q     <= '0;
      rr_q    <= '0;
      rn_q    <= '0;
      lb_q    <= '0;
      st_q    <= '0;
      cp_q    <= '0;
      ht_q    <= '0;
      tgt_q   <= '0;
      nlb_q   <= '0;
      nst_q   <= '0;
      ncp_q   <= '0;
      ra_q    <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          op_q    <= op_e'(op_i);
          n_q     <= fld_n_i;
          d_q     <= fld_d_i;
          rr_q    <= reg_r_val_i;
          rn_q    <= reg_n_val_i;
          lb_q    <= lb_i;
          st_q    <= st_i;
          cp_q    <= cp_i;
          ht_q    <= ht_i;
          state_q <= S_DEC;
        end
        S_DEC: begin
          unique case (op_q)
            OP_CALL: begin
              if (is_prim) begin
                tgt_q   <= tgt_c;
                state_q <= S_PRIM;
              end else if (!is_code || !room) begin
                state_q <= S_ERR;
              end else begin
                ncp_q   <= tgt_c;
                nlb_q   <= st_q;
                nst_q   <= st_q + DW'(3);
                cnt_q   <= '0;
                state_q <= S_FRAME;
              end
            end
            OP_CALLI: state_q <= (st_q < DW'(2)) ? S_ERR : S_CJ_RD;
            OP_RET:   state_q <= ret_bad_c ? S_ERR : S_RET_RA;
            default:  state_q <= S_ERR;
          endcase
        end
        S_CJ_RD: state_q <= S_CJ_CHK;
        S_CJ_CHK: begin
          if (is_prim) begin
            tgt_q   <= tgt_c;
            state_q <= S_PRIM;
          end else if (!is_code || !room) begin
            state_q <= S_ERR;
          end else begin
            ncp_q   <= tgt_c;
            nlb_q   <= st_q - DW'(2);
            nst_q   <= st_q + DW'(1);
            cnt_q   <= '0;
            state_q <= S_FRAME;
          end
        end
        S_FRAME: begin
          cnt_q <= cnt_q + NW'(1);
          if (frame_last_c) state_q <= S_COMMIT;
        end
        S_RET_RA: state_q <= S_RET_DL;
        S_RET_DL: begin
          ra_q    <= mem_rdata_i;
          state_q <= S_RET_CAP;
        end
        S_RET_CAP: begin
          nlb_q   <= mem_rdata_i;
          ncp_q   <= ra_q;
          nst_q   <= lb_q - d_q + DW'(n_q);
          cnt_q   <= '0;
          state_q <= (n_q == '0) ? S_COMMIT : S_MV_RD;
        end
        S_MV_RD: state_q <= S_MV_WR;
        S_MV_WR: begin
          cnt_q   <= cnt_q + NW'(1);
          state_q <= (cnt_q == n_q - NW'(1)) ? S_COMMIT : S_MV_RD;
        end
        S_COMMIT: state_q <= S_WALK;
        S_WALK:   if (w_done) state_q <= S_DONE;
        S_PRIM:   if (prim_ack_i) state_q <= S_PFIN;
        S_PFIN:   state_q <= S_DONE;
        S_DONE:   state_q <= S_IDLE;
        S_ERR:    state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      S_CJ_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = st_q - DW'(1);
      end
      S_FRAME: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = ((op_q == OP_CALLI) ? st_q - DW'(1) : st_q) + DW'(cnt_q);
        unique case (fidx_c)
          2'd0:    mem_wdata_o = rn_q;
          2'd1:    mem_wdata_o = lb_q;
          default: mem_wdata_o = cp1_c;
        endcase
      end
      S_RET_RA: begin
        mem_req_o  = 1'b1;
        mem_addr_o = lb_q + DW'(2);
      end
      S_RET_DL: begin
        mem_req_o  = 1'b1;
        mem_addr_o = lb_q + DW'(1);
      end
      S_MV_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = st_q - DW'(n_q) + DW'(cnt_q);
      end
      S_MV_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = lb_q - d_q + DW'(cnt_q);
        mem_wdata_o = mem_rdata_i;
      end
      S_WALK: begin
        mem_req_o  = w_req;
        mem_addr_o = w_addr;
      end
      default: ;
    endcase
  end

  assign lb_we_o    = (state_q == S_COMMIT);
  assign st_we_o    = (state_q == S_COMMIT);
  assign cp_we_o    = (state_q == S_COMMIT) || (state_q == S_PFIN);
  assign lb_o       = nlb_q;
  assign st_o       = nst_q;
  assign cp_o       = (state_q == S_PFIN) ? cp1_c : ncp_q;
  assign prim_req_o = (state_q == S_PRIM);
  assign prim_id_o  = PIW'(tgt_q - CODE_BASE);
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_DONE) || (state_q == S_ERR);
  assign err_o      = (state_q == S_ERR);
endmodule

// File: rtl/frame_unit_chk.sv
module frame_unit_chk #(
  parameter int unsigned NDISP = 6,
  parameter int unsigned PIW   = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic             mem_we_o,
  input logic             lb_we_o,
  input logic             st_we_o,
  input logic             cp_we_o,
  input logic [NDISP-1:0] disp_we_o,
  input logic             prim_req_o,
  input logic [PIW-1:0]   prim_id_o,
  input logic             prim_ack_i
);
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R1
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R1
  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o); // R1
  AST_DISP_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(disp_we_o)); // R5
  AST_PRIM_NO_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prim_req_o |-> !mem_we_o && (disp_we_o == '0) && !lb_we_o && !st_we_o); // R6
  AST_PRIM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prim_req_o && !prim_ack_i |=> prim_req_o && $stable(prim_id_o)); // R6
  AST_ERR_NO_REG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !lb_we_o && !st_we_o && !cp_we_o && !mem_we_o); // R7
endmodule

bind frame_unit frame_unit_chk #(.NDISP(NDISP), .PIW(PIW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .mem_we_o  (mem_we_o),
  .lb_we_o   (lb_we_o),
  .st_we_o   (st_we_o),
  .cp_we_o   (cp_we_o),
  .disp_we_o (disp_we_o),
  .prim_req_o(prim_req_o),
  .prim_id_o (prim_id_o),
  .prim_ack_i(prim_ack_i)
);

// File: tb/frame_unit_tb.sv
`timescale 1ns/1ps
module frame_unit_tb;
  localparam int DW = 16, NW = 8, ND = 6, CL = 1024, PC = 28, PIW = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic start_i = 0, prim_ack_i = 0;
  logic [1:0] op_i = 0;
  logic [NW-1:0] fld_n_i = 0;
  logic [DW-1:0] fld_d_i = 0, reg_r_val_i = 0, reg_n_val_i = 0, ht_i = 16'd200;
  logic [DW-1:0] mem_rdata_i;
  logic mem_req_o, mem_we_o, lb_we_o, st_we_o, cp_we_o, prim_req_o, busy_o, done_o, err_o;
  logic [DW-1:0] mem_addr_o, mem_wdata_o, lb_o, st_o, cp_o, disp_o;
  logic [ND-1:0] disp_we_o;
  logic [PIW-1:0] prim_id_o;

  logic [DW-1:0] mem [256];
  logic [DW-1:0] lb_m, st_m, cp_m;
  logic [DW-1:0] disp_m [ND];
  int wr_cnt = 0, dw_cnt = 0, lbw_cnt = 0;
  logic poke_v = 0, set_v = 0;
  logic [7:0] poke_a = 0;
  logic [DW-1:0] poke_d = 0, set_lb = 0, set_st = 0, set_cp = 0;
  int total = 0, bad = 0, pcnt = 0;
  logic [PIW-1:0] prim_seen = 0;
  logic last_err;

  frame_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .fld_n_i(fld_n_i), .fld_d_i(fld_d_i), .reg_r_val_i(reg_r_val_i),
    .reg_n_val_i(reg_n_val_i), .lb_i(lb_m), .st_i(st_m), .cp_i(cp_m), .ht_i(ht_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .lb_we_o(lb_we_o), .lb_o(lb_o), .st_we_o(st_we_o), .st_o(st_o),
    .cp_we_o(cp_we_o), .cp_o(cp_o), .disp_we_o(disp_we_o), .disp_o(disp_o),
    .prim_req_o(prim_req_o), .prim_id_o(prim_id_o), .prim_ack_i(prim_ack_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  // memory and register-file model
  always @(posedge clk) begin
    if (poke_v) mem[poke_a] <= poke_d;
    if (mem_req_o && mem_we_o) begin
      mem[mem_addr_o[7:0]] <= mem_wdata_o;
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_req_o && !mem_we_o) mem_rdata_i <= mem[mem_addr_o[7:0]];
    if (set_v) begin
      lb_m <= set_lb; st_m <= set_st; cp_m <= set_cp;
    end else begin
      if (lb_we_o) begin lb_m <= lb_o; lbw_cnt <= lbw_cnt + 1; end
      if (st_we_o) st_m <= st_o;
      if (cp_we_o) cp_m <= cp_o;
    end
    for (int k = 0; k < ND; k++) if (disp_we_o[k]) disp_m[k] <= disp_o;
    if (disp_we_o != '0) dw_cnt <= dw_cnt + 1;
  end

  // primitive unit model: acknowledge after three cycles
  always @(negedge clk) begin
    if (prim_req_o && !prim_ack_i) begin
      prim_seen = prim_id_o;
      pcnt = pcnt + 1;
      if (pcnt == 3) begin prim_ack_i = 1; pcnt = 0; end
    end else prim_ack_i = 0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [DW-1:0] d);
    @(negedge clk); poke_a = a; poke_d = d; poke_v = 1;
    @(negedge clk); poke_v = 0;
  endtask

  task automatic set_regs(input logic [DW-1:0] lb, input logic [DW-1:0] st, input logic [DW-1:0] cp);
    @(negedge clk); set_lb = lb; set_st = st; set_cp = cp; set_v = 1;
    @(negedge clk); set_v = 0;
  endtask

  int w0, d0, l0;
  task automatic run_op(input logic [1:0] op, input logic [NW-1:0] n, input logic [DW-1:0] d,
                        input logic [DW-1:0] rr, input logic [DW-1:0] rn);
    int cyc;
    @(negedge clk);
    w0 = wr_cnt; d0 = dw_cnt; l0 = lbw_cnt;
    op_i = op; fld_n_i = n; fld_d_i = d; reg_r_val_i = rr; reg_n_val_i = rn; start_i = 1;
    @(negedge clk); start_i = 0; cyc = 0;
    while (!done_o && cyc < 300) begin @(negedge clk); cyc++; end
    chk("R1 done seen", done_o, 1);
    last_err = err_o;
    @(negedge clk);
    chk("R1 done one cycle", done_o, 0);
  endtask

  task automatic check_disp(input string tag, input logic [DW-1:0] base);
    logic [DW-1:0] p = base;
    for (int k = 0; k < ND; k++) begin
      p = mem[p[7:0]];
      chk(tag, disp_m[k], p);
    end
  endtask

  task automatic t_reset();
    chk("R1 reset done", done_o, 0);
    chk("R1 reset err", err_o, 0);
    chk("R1 reset busy", busy_o, 0);
    chk("R6 reset prim", prim_req_o, 0);
  endtask

  task automatic t_call_basic();
    set_regs(10, 20, 5);
    run_op(0, 0, 4, 100, 10);
    chk("R1 call err", last_err, 0);
    chk("R2 writes", wr_cnt - w0, 3);
    chk("R2 sl", mem[20], 10); chk("R2 dl", mem[21], 10); chk("R2 ra", mem[22], 6);
    chk("R3 lb", lb_m, 20); chk("R3 st", st_m, 23); chk("R3 cp", cp_m, 104);
    check_disp("R5 disp call", 20);
    chk("R5 disp writes", dw_cnt - d0, ND);
  endtask

  task automatic t_call_outer();
    run_op(0, 0, 0, 200, 3);
    chk("R2 sl outer", mem[23], 3); chk("R2 dl outer", mem[24], 20); chk("R2 ra outer", mem[25], 105);
    chk("R3 lb outer", lb_m, 23); chk("R3 st outer", st_m, 26); chk("R3 cp outer", cp_m, 200);
    check_disp("R5 disp outer", 23);
  endtask

  task automatic t_overflow();
    set_regs(10, 40, 5); ht_i = 42;
    run_op(0, 0, 0, 50, 10);
    chk("R8 call ovf err", last_err, 1);
    chk("R8 call ovf writes", wr_cnt - w0, 0);
    chk("R8 call ovf st", st_m, 40);
    poke(39, 50); ht_i = 40;
    run_op(1, 0, 0, 0, 0);
    chk("R8 calli ovf err", last_err, 1);
    chk("R8 calli ovf writes", wr_cnt - w0, 0);
    set_regs(10, 1, 5);
    run_op(1, 0, 0, 0, 0);
    chk("R8 calli low st err", last_err, 1);
    set_regs(10, 40, 5); ht_i = 43;
    run_op(0, 0, 0, 50, 10);
    chk("R8 exact limit ok", last_err, 0);
    chk("R8 exact limit st", st_m, 43);
    ht_i = 200;
  endtask

  task automatic t_bad_target();
    set_regs(10, 20, 5);
    run_op(0, 0, 0, CL + PC, 10);
    chk("R7 err", last_err, 1);
    chk("R7 writes", wr_cnt - w0, 0);
    chk("R7 cp", cp_m, 5);
  endtask

  task automatic t_call_prim();
    set_regs(10, 20, 7);
    run_op(0, 0, 5, CL, 10);
    chk("R6 err", last_err, 0);
    chk("R6 id", prim_seen, 5);
    chk("R6 writes", wr_cnt - w0, 0);
    chk("R6 disp", dw_cnt - d0, 0);
    chk("R6 lb", lb_m, 10); chk("R6 st", st_m, 20); chk("R6 cp", cp_m, 8);
  endtask

  task automatic t_calli();
    poke(28, 7); poke(29, 120); poke(7, 2); poke(2, 0); poke(0, 0);
    set_regs(20, 30, 50);
    run_op(1, 0, 0, 0, 0);
    chk("R4 err", last_err, 0);
    chk("R4 writes", wr_cnt - w0, 2);
    chk("R4 sl kept", mem[28], 7); chk("R4 dl", mem[29], 20); chk("R4 ra", mem[30], 51);
    chk("R4 lb", lb_m, 28); chk("R4 st", st_m, 31); chk("R4 cp", cp_m, 120);
    check_disp("R5 disp calli", 28);
  endtask

  task automatic t_calli_prim();
    poke(48, 9); poke(49, CL + 6);
    set_regs(20, 50, 60);
    run_op(1, 0, 0, 0, 0);
    chk("R6 calli id", prim_seen, 6);
    chk("R6 calli writes", wr_cnt - w0, 0);
    chk("R6 calli sl", mem[48], 9);
    chk("R6 calli lb", lb_m, 20); chk("R6 calli cp", cp_m, 61);
  endtask

  task automatic t_ret_func();
    poke(40, 3); poke(41, 20); poke(42, 77); poke(45, 16'h1234);
    set_regs(40, 46, 90);
    run_op(2, 1, 2, 0, 0);
    chk("R9 err", last_err, 0);
    chk("R9 result", mem[38], 16'h1234);
    chk("R9 writes", wr_cnt - w0, 1);
    chk("R9 lb", lb_m, 20); chk("R9 st", st_m, 39); chk("R9 cp", cp_m, 77);
    check_disp("R5 disp ret", 20);
  endtask

  task automatic t_ret_proc();
    poke(60, 3); poke(61, 10); poke(62, 88);
    set_regs(60, 63, 91);
    run_op(2, 0, 0, 0, 0);
    chk("R10 writes", wr_cnt - w0, 0);
    chk("R10 lb", lb_m, 10); chk("R10 st", st_m, 60); chk("R10 cp", cp_m, 88);
  endtask

  task automatic t_ret_two();
    poke(70, 3); poke(71, 10); poke(72, 99); poke(73, 16'hAAAA); poke(74, 16'hBBBB);
    set_regs(70, 75, 92);
    run_op(2, 2, 1, 0, 0);
    chk("R9 two w0", mem[69], 16'hAAAA); chk("R9 two w1", mem[70], 16'hBBBB);
    chk("R9 two st", st_m, 71); chk("R9 two cp", cp_m, 99); chk("R9 two lb", lb_m, 10);
  endtask

  task automatic t_ret_under();
    set_regs(80, 82, 5);
    run_op(2, 0, 0, 0, 0);
    chk("R11 short err", last_err, 1);
    chk("R11 short writes", lbw_cnt - l0, 0);
    chk("R11 short lb", lb_m, 80);
    set_regs(2, 10, 5);
    run_op(2, 0, 5, 0, 0);
    chk("R11 disp err", last_err, 1);
    chk("R11 disp writes", wr_cnt - w0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    lb_m = 0; st_m = 0; cp_m = 0; mem_rdata_i = 0;
    for (int k = 0; k < ND; k++) disp_m[k] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    poke(10, 3); poke(3, 1); poke(1, 0);
    t_call_basic();
    t_call_outer();
    t_overflow();
    t_bad_target();
    t_call_prim();
    t_calli();
    t_calli_prim();
    t_ret_func();
    t_ret_proc();
    t_ret_two();
    t_ret_under();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule